// File: doc/BRIEF.md
# ATA Device Register File (Taskfile Front End)

This block is the device-side register file of an ATA disk interface. A host reaches it through two chip-select windows: window 0 carries the eight command-block registers (data, error/feature, sector count, sector number, the two cylinder bytes, device/head and status/command), and window 1 carries the single control-block register (alternate status on read, device control on write). The block stores the taskfile parameters, keeps the status byte, tracks which drive of a master/slave pair the host addressed, and decides for every access whether it is legal under the current BSY, DRQ, DMA-acknowledge and drive-selection conditions.

A command write is handed to the execution engine as a one-cycle strobe with the opcode. The engine, which is outside this block, loads new status values and raises interrupts through a small side port. Software reset through the device control register is timed here by a cycle counter. Data-port accesses are only qualified and strobed; the sector buffer itself lives elsewhere.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After synchronous reset the status byte is 0x50 when `media_ready` is high (0x10 when low), `irq` and `cmd_stb` are low, and the sector count output is 1.
- R2: Window 0 offsets 1 (write: feature), 2, 3, 4, 5 and 6 hold feature, sector count, sector number, cylinder low, cylinder high and device/head; reads return the stored byte zero-extended, offset 1 read returns `err_in`, and window 1 offsets other than 6 read as 0xFFFF.
- R3: Writing 0 to sector count (window 0 offset 2) stores 256; the register read returns its low byte, and the stored count is never 0.
- R4: A device/head write sets the drive number from bit 4 and the head from bits 3:0; the device is selected when the drive number equals `dev_addr`.
- R5: When not selected and `other_present` is high, every read returns 0xFFFF; when not selected, `dev_addr` is 0 and `other_present` is low, status, alternate status and data reads return 0 while the other taskfile registers return their values.
- R6: While `dmack` is high, every read on either window returns 0xFFFF and every write is dropped.
- R7: While status bit 7 (BSY) is set, window 0 writes other than command (offset 7) are dropped; a selected device answers reads of offsets 1 to 6 with the status byte and a data read with 0xFFFF.
- R8: While status bit 3 (DRQ) is set, window 0 writes other than data and command are dropped; a data access by a selected, non-busy device with DRQ set pulses `data_rd_stb` or `data_wr_stb` in the access cycle and a data read returns `pio_rdata`; without DRQ a data read returns 0xFFFF and a data write produces no strobe.
- R9: A selected read of status (window 0 offset 7) clears the pending interrupt; a read of alternate status (window 1 offset 6) returns the same byte and leaves it pending; an engine interrupt in the same cycle wins.
- R10: Device control bit 1 masks the `irq` output while the interrupt stays pending.
- R11: A command write is always latched into `cmd_opcode`; `cmd_stb` rises for one cycle after the write only if the device is selected or the opcode is 0x90.
- R12: A device control write with bit 2 set sets BSY and clears DRDY (bit 6) in the next cycle; after `RST_CYCLES` cycles status becomes 0x10 with DRDY copied from `media_ready`; engine status loads are ignored meanwhile.
- R13: Outside software reset, an `eng_status_we` pulse loads `eng_status` into the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_win | input | 1 | Window select: 0 = command block, 1 = control block |
| acc_off | input | 3 | Register offset within the window |
| acc_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid in the access cycle |
| dev_addr | input | 1 | Own drive number from cable select |
| other_present | input | 1 | Another device is present on the cable |
| dmack | input | 1 | DMA acknowledge from the host |
| media_ready | input | 1 | Media reports ready |
| err_in | input | 8 | Error byte from the execution engine |
| pio_rdata | input | DATA_W | Data word from the sector buffer |
| pio_wdata | output | DATA_W | Data word toward the sector buffer |
| data_rd_stb | output | 1 | Qualified data-port read |
| data_wr_stb | output | 1 | Qualified data-port write |
| eng_status_we | input | 1 | Engine loads the status byte |
| eng_status | input | 8 | Status value from the engine |
| eng_set_irq | input | 1 | Engine raises the interrupt |
| irq | output | 1 | Interrupt request level |
| cmd_stb | output | 1 | One-cycle new-command strobe |
| cmd_opcode | output | 8 | Last written command opcode |
| feature | output | 8 | Feature register |
| sec_count | output | 9 | Sector count, 1 to 256 |
| sec_num | output | 8 | Sector number |
| cylinder | output | 16 | Cylinder high and low bytes |
| drive | output | 1 | Addressed drive number |
| head | output | 4 | Head number |
| nien | output | 1 | Interrupt mask from device control |
| srst_busy | output | 1 | Software reset in progress |

## Verification
The embedded properties watch on every cycle that DMA acknowledge forces all-ones read data, that a busy device keeps its sector number through a write, that the sector count never holds zero, that a command strobe only follows an accepted command write, that a status read drops the pending interrupt and that a reset request raises BSY and drops DRDY. The bench scenarios are needed for the value-level behaviour: the register read-back paths, the split read/write meanings of offsets 1 and 7, the two unselected-device answers, the diagnostic opcode exception, the interrupt mask and the restored status after the reset countdown with the media ready or not.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;

    // window 0 offsets (read meaning / write meaning where they differ)
    localparam logic [2:0] OFF_DATA    = 3'd0;
    localparam logic [2:0] OFF_ERRFEAT = 3'd1;
    localparam logic [2:0] OFF_SCNT    = 3'd2;
    localparam logic [2:0] OFF_SNUM    = 3'd3;
    localparam logic [2:0] OFF_CYLLO   = 3'd4;
    localparam logic [2:0] OFF_CYLHI   = 3'd5;
    localparam logic [2:0] OFF_DEVHEAD = 3'd6;
    localparam logic [2:0] OFF_STATCMD = 3'd7;
    // window 1 offset
    localparam logic [2:0] OFF_CTRL    = 3'd6;

    // status bit positions
    localparam int ST_ERR  = 0;
    localparam int ST_IDX  = 1;
    localparam int ST_CORR = 2;
    localparam int ST_DRQ  = 3;
    localparam int ST_DSC  = 4;
    localparam int ST_DWF  = 5;
    localparam int ST_DRDY = 6;
    localparam int ST_BSY  = 7;

    // device control bit positions
    localparam int CTL_NIEN = 1;
    localparam int CTL_SRST = 2;

    localparam logic [7:0] OP_DIAG = 8'h90;
    localparam int         SCNT_W  = 9;

    // byte-wide taskfile slots held in a generated register row
    localparam int N_TF8  = 5;
    localparam int T_FEAT = 0;
    localparam int T_SNUM = 1;
    localparam int T_CYLLO = 2;
    localparam int T_CYLHI = 3;
    localparam int T_DH   = 4;

    typedef enum logic [2:0] {
        RS_ZERO,
        RS_ONES,
        RS_STATUS,
        RS_PIO,
        RS_TASKFILE
    } rd_src_e;

    typedef struct packed {
        logic [N_TF8-1:0] tf8;
        logic             scnt;
        logic             cmd;
        logic             data;
        logic             ctrl;
    } wr_en_t;

    function automatic logic [N_TF8-1:0] off_to_slot(input logic [2:0] off);
        logic [N_TF8-1:0] m;
        m = '0;
        case (off)
            OFF_ERRFEAT: m[T_FEAT]  = 1'b1;
            OFF_SNUM:    m[T_SNUM]  = 1'b1;
            OFF_CYLLO:   m[T_CYLLO] = 1'b1;
            OFF_CYLHI:   m[T_CYLHI] = 1'b1;
            OFF_DEVHEAD: m[T_DH]    = 1'b1;
            default:     m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] idle_status(input logic ready);
        logic [7:0] s;
        s = '0;
        s[ST_DSC]  = 1'b1;
        s[ST_DRDY] = ready;
        return s;
    endfunction

    function automatic logic [7:0] tf8_reset(input int slot);
        return (slot == T_SNUM) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/ata_tf_gate.sv
`timescale 1ns/1ps
module ata_tf_gate
    import ata_tf_pkg::*;
(
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_win,
    input  logic [2:0] acc_off,
    input  logic       dmack,
    input  logic       selected,
    input  logic       single_dev,
    input  logic       busy,
    input  logic       drq,
    output wr_en_t     wr_en,
    output rd_src_e    rd_src,
    output logic       status_rd_clr,
    output logic       data_rd_stb
);

    logic wr_ok;
    logic cs0_ok;

    // read source selection
    always_comb begin
        rd_src = RS_ZERO;
        if (acc_valid && !acc_write) begin
            if (dmack || (!selected && !single_dev)) begin
                rd_src = RS_ONES;
            end else if (acc_win) begin
                if (acc_off == OFF_CTRL)
                    rd_src = selected ? RS_STATUS : RS_ZERO;
                else
                    rd_src = RS_ONES;
            end else if (busy && acc_off != OFF_STATCMD) begin
                if (!selected)
                    rd_src = RS_ZERO;
                else if (acc_off == OFF_DATA)
                    rd_src = RS_ONES;
                else
                    rd_src = RS_STATUS;
            end else begin
                case (acc_off)
                    OFF_DATA:    rd_src = !selected ? RS_ZERO : (drq ? RS_PIO : RS_ONES);
                    OFF_STATCMD: rd_src = selected ? RS_STATUS : RS_ZERO;
                    default:     rd_src = RS_TASKFILE;
                endcase
            end
        end
    end

    assign status_rd_clr = (rd_src == RS_STATUS) && !acc_win && (acc_off == OFF_STATCMD);
    assign data_rd_stb   = (rd_src == RS_PIO);

    // write qualification
    assign wr_ok  = acc_valid && acc_write && !dmack;
    assign cs0_ok = wr_ok && !acc_win
                 && !(busy && acc_off != OFF_STATCMD)
                 && !(drq && acc_off != OFF_DATA && acc_off != OFF_STATCMD);

    always_comb begin
        wr_en      = '0;
        wr_en.tf8  = cs0_ok ? off_to_slot(acc_off) : '0;
        wr_en.scnt = cs0_ok && (acc_off == OFF_SCNT);
        wr_en.cmd  = cs0_ok && (acc_off == OFF_STATCMD);
        wr_en.data = cs0_ok && (acc_off == OFF_DATA) && selected && drq;
        wr_en.ctrl = wr_ok && acc_win && (acc_off == OFF_CTRL);
    end

endmodule

// File: rtl/ata_tf_file.sv
`timescale 1ns/1ps
module ata_tf_file
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_en_t            wr_en,
    input  logic [7:0]        wdata,
    input  logic              selected,
    input  logic [2:0]        rd_off,
    output logic [7:0]        rd_byte,
    output logic [7:0]        feature,
    output logic [SCNT_W-1:0] sec_count,
    output logic [7:0]        sec_num,
    output logic [15:0]       cylinder,
    output logic [7:0]        devhead,
    output logic [7:0]        cmd_opcode,
    output logic              cmd_stb
);

    logic [7:0] tf_vec [N_TF8];

    for (genvar g = 0; g < N_TF8; g++) begin : g_tf8
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= tf8_reset(g);
            else if (wr_en.tf8[g])
                q <= wdata;
        end
        assign tf_vec[g] = q;
    end

    // sector count: zero written means 256
    always_ff @(posedge clk) begin
        if (rst)
            sec_count <= SCNT_W'(1);
        else if (wr_en.scnt)
            sec_count <= (wdata == 8'h00) ? SCNT_W'(256) : SCNT_W'(wdata);
    end

    // command latch and hand-off strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_opcode <= 8'h00;
            cmd_stb    <= 1'b0;
        end else begin
            cmd_stb <= wr_en.cmd && (selected || wdata == OP_DIAG);
            if (wr_en.cmd)
                cmd_opcode <= wdata;
        end
    end

    assign feature  = tf_vec[T_FEAT];
    assign sec_num  = tf_vec[T_SNUM];
    assign cylinder = {tf_vec[T_CYLHI], tf_vec[T_CYLLO]};
    assign devhead  = tf_vec[T_DH];

    always_comb begin
        case (rd_off)
            OFF_SCNT:    rd_byte = sec_count[7:0];
            OFF_SNUM:    rd_byte = tf_vec[T_SNUM];
            OFF_CYLLO:   rd_byte = tf_vec[T_CYLLO];
            OFF_CYLHI:   rd_byte = tf_vec[T_CYLHI];
            OFF_DEVHEAD: rd_byte = tf_vec[T_DH];
            default:     rd_byte = 8'h00;
        endcase
    end

    assert_scnt_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        sec_count != '0);

    assert_cmd_from_write_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> $past(wr_en.cmd));

endmodule

// File: rtl/ata_tf_stat.sv
`timescale 1ns/1ps
module ata_tf_stat
    import ata_tf_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 625000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       media_ready,
    input  logic       ctrl_we,
    input  logic       ctrl_nien,
    input  logic       ctrl_srst,
    input  logic       status_rd_clr,
    input  logic       eng_status_we,
    input  logic [7:0] eng_status,
    input  logic       eng_set_irq,
    output logic [7:0] status,
    output logic       irq,
    output logic       nien,
    output logic       srst_busy
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             irq_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= idle_status(media_ready);
            srst_busy <= 1'b0;
            cnt_q     <= '0;
            nien      <= 1'b0;
        end else begin
            if (ctrl_we)
                nien <= ctrl_nien;
            if (ctrl_we && ctrl_srst) begin
                status[ST_BSY]  <= 1'b1;
                status[ST_DRDY] <= 1'b0;
                srst_busy       <= 1'b1;
                cnt_q           <= CNT_W'(RST_CYCLES - 1);
            end else if (srst_busy) begin
                if (cnt_q == '0) begin
                    srst_busy <= 1'b0;
                    status    <= idle_status(media_ready);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end else if (eng_status_we) begin
                status <= eng_status;
            end
        end
    end

    // pending interrupt: engine set wins over a status-read clear
    always_ff @(posedge clk) begin
        if (rst)
            irq_pend <= 1'b0;
        else if (eng_set_irq)
            irq_pend <= 1'b1;
        else if (status_rd_clr)
            irq_pend <= 1'b0;
    end

    assign irq = irq_pend && !nien;

    assert_rd_clears_irq_R9: assert property (@(posedge clk) disable iff (rst)
        (status_rd_clr && !eng_set_irq) |=> !irq_pend);

    assert_srst_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_srst) |=> (status[ST_BSY] && !status[ST_DRDY]));

    assert_srst_ends_R12: assert property (@(posedge clk) disable iff (rst)
        (srst_busy && cnt_q == '0 && !(ctrl_we && ctrl_srst)) |=> !status[ST_BSY]);

endmodule

// File: rtl/ata_taskfile_regs.sv
`timescale 1ns/1ps
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int unsigned RST_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_win,
    input  logic [2:0]        acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dev_addr,
    input  logic              other_present,
    input  logic              dmack,
    input  logic              media_ready,
    input  logic [7:0]        err_in,
    input  logic [DATA_W-1:0] pio_rdata,
    output logic [DATA_W-1:0] pio_wdata,
    output logic              data_rd_stb,
    output logic              data_wr_stb,
    input  logic              eng_status_we,
    input  logic [7:0]        eng_status,
    input  logic              eng_set_irq,
    output logic              irq,
    output logic              cmd_stb,
    output logic [7:0]        cmd_opcode,
    output logic [7:0]        feature,
    output logic [SCNT_W-1:0] sec_count,
    output logic [7:0]        sec_num,
    output logic [15:0]       cylinder,
    output logic              drive,
    output logic [3:0]        head,
    output logic              nien,
    output logic              srst_busy
);

    localparam int PAD_W = DATA_W - 8;

    wr_en_t     wr_en;
    rd_src_e    rd_src;
    logic       status_rd_clr;
    logic [7:0] status;
    logic [7:0] devhead;
    logic [7:0] tf_byte;
    logic       selected;
    logic       single_dev;

    assign drive      = devhead[4];
    assign head       = devhead[3:0];
    assign selected   = (drive == dev_addr);
    assign single_dev = !dev_addr && !other_present;

    ata_tf_gate u_gate (
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_win       (acc_win),
        .acc_off       (acc_off),
        .dmack         (dmack),
        .selected      (selected),
        .single_dev    (single_dev),
        .busy          (status[ST_BSY]),
        .drq           (status[ST_DRQ]),
        .wr_en         (wr_en),
        .rd_src        (rd_src),
        .status_rd_clr (status_rd_clr),
        .data_rd_stb   (data_rd_stb)
    );

    ata_tf_file u_file (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wdata      (acc_wdata[7:0]),
        .selected   (selected),
        .rd_off     (acc_off),
        .rd_byte    (tf_byte),
        .feature    (feature),
        .sec_count  (sec_count),
        .sec_num    (sec_num),
        .cylinder   (cylinder),
        .devhead    (devhead),
        .cmd_opcode (cmd_opcode),
        .cmd_stb    (cmd_stb)
    );

    ata_tf_stat #(.RST_CYCLES(RST_CYCLES)) u_stat (
        .clk           (clk),
        .rst           (rst),
        .media_ready   (media_ready),
        .ctrl_we       (wr_en.ctrl),
        .ctrl_nien     (acc_wdata[CTL_NIEN]),
        .ctrl_srst     (acc_wdata[CTL_SRST]),
        .status_rd_clr (status_rd_clr),
        .eng_status_we (eng_status_we),
        .eng_status    (eng_status),
        .eng_set_irq   (eng_set_irq),
        .status        (status),
        .irq           (irq),
        .nien          (nien),
        .srst_busy     (srst_busy)
    );

    assign data_wr_stb = wr_en.data;
    assign pio_wdata   = acc_wdata;

    always_comb begin
        case (rd_src)
            RS_ONES:     host_rdata = '1;
            RS_STATUS:   host_rdata = {{PAD_W{1'b0}}, status};
            RS_PIO:      host_rdata = pio_rdata;
            RS_TASKFILE: host_rdata = {{PAD_W{1'b0}},
                                       (acc_off == OFF_ERRFEAT) ? err_in : tf_byte};
            default:     host_rdata = '0;
        endcase
    end

    assert_dmack_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && dmack) |-> (host_rdata == '1));

    assert_busy_keeps_snum_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_win && acc_off == OFF_SNUM && status[ST_BSY])
        |=> $stable(sec_num));

endmodule

// File: tb/sim_ata_taskfile_regs.sv
`timescale 1ns/1ps
module sim_ata_taskfile_regs;

    localparam int N_RST = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_win = 1'b0;
    logic [2:0]  acc_off = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] host_rdata, pio_wdata;
    logic        dev_addr = 1'b0, other_present = 1'b1, dmack = 1'b0, media_ready = 1'b1;
    logic [7:0]  err_in = 8'h04;
    logic [15:0] pio_rdata = 16'hBEEF;
    logic        data_rd_stb, data_wr_stb;
    logic        eng_status_we = 1'b0, eng_set_irq = 1'b0;
    logic [7:0]  eng_status = '0;
    logic        irq, cmd_stb, drive, nien, srst_busy;
    logic [7:0]  cmd_opcode, feature, sec_num;
    logic [8:0]  sec_count;
    logic [15:0] cylinder;
    logic [3:0]  head;

    int tests = 0;
    int fails = 0;
    logic        done = 1'b0;
    logic [15:0] last_rd;
    logic        last_drd, last_dwr;

    always #4 clk = ~clk;

    ata_taskfile_regs #(.DATA_W(16), .RST_CYCLES(N_RST)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_win(acc_win), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .host_rdata(host_rdata), .dev_addr(dev_addr), .other_present(other_present),
        .dmack(dmack), .media_ready(media_ready), .err_in(err_in),
        .pio_rdata(pio_rdata), .pio_wdata(pio_wdata), .data_rd_stb(data_rd_stb),
        .data_wr_stb(data_wr_stb), .eng_status_we(eng_status_we),
        .eng_status(eng_status), .eng_set_irq(eng_set_irq), .irq(irq),
        .cmd_stb(cmd_stb), .cmd_opcode(cmd_opcode), .feature(feature),
        .sec_count(sec_count), .sec_num(sec_num), .cylinder(cylinder),
        .drive(drive), .head(head), .nien(nien), .srst_busy(srst_busy)
    );

    // {wr, win, off, wdata, expected read, requirement}
    localparam logic [40:0] VEC [16] = '{
        {1'b1, 1'b0, 3'd1, 16'h0012, 16'h0000, 4'd2},
        {1'b1, 1'b0, 3'd2, 16'h0007, 16'h0000, 4'd2},
        {1'b0, 1'b0, 3'd2, 16'h0000, 16'h0007, 4'd2},
        {1'b1, 1'b0, 3'd3, 16'h0021, 16'h0000, 4'd2},
        {1'b0, 1'b0, 3'd3, 16'h0000, 16'h0021, 4'd2},
        {1'b1, 1'b0, 3'd4, 16'h0034, 16'h0000, 4'd2},
        {1'b1, 1'b0, 3'd5, 16'h0056, 16'h0000, 4'd2},
        {1'b0, 1'b0, 3'd4, 16'h0000, 16'h0034, 4'd2},
        {1'b0, 1'b0, 3'd5, 16'h0000, 16'h0056, 4'd2},
        {1'b1, 1'b0, 3'd6, 16'h00E5, 16'h0000, 4'd4},
        {1'b0, 1'b0, 3'd6, 16'h0000, 16'h00E5, 4'd4},
        {1'b0, 1'b0, 3'd1, 16'h0000, 16'h0004, 4'd2},
        {1'b0, 1'b0, 3'd7, 16'h0000, 16'h0050, 4'd1},
        {1'b0, 1'b1, 3'd6, 16'h0000, 16'h0050, 4'd9},
        {1'b0, 1'b0, 3'd0, 16'h0000, 16'hFFFF, 4'd8},
        {1'b0, 1'b1, 3'd3, 16'h0000, 16'hFFFF, 4'd2}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic win, input logic [2:0] off,
                       input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_win = win; acc_off = off; acc_wdata = d;
        #1;
        last_rd  = host_rdata;
        last_drd = data_rd_stb;
        last_dwr = data_wr_stb;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic eng_load(input logic [7:0] s);
        @(negedge clk); eng_status_we = 1'b1; eng_status = s;
        @(negedge clk); eng_status_we = 1'b0;
    endtask

    task automatic eng_irq();
        @(negedge clk); eng_set_irq = 1'b1;
        @(negedge clk); eng_set_irq = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 cmd_stb", {15'd0, cmd_stb}, 16'd0);
        chk("R1 sec_count", {7'd0, sec_count}, 16'd1);

        for (int i = 0; i < 16; i++) begin
            acc(VEC[i][40], VEC[i][39], VEC[i][38:36], VEC[i][35:20]);
            if (!VEC[i][40])
                chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), last_rd, VEC[i][19:4]);
        end
        chk("R2 cylinder out", cylinder, 16'h5634);
        chk("R2 feature out", {8'd0, feature}, 16'h0012);
        chk("R4 head", {12'd0, head}, 16'h0005);
        chk("R4 drive", {15'd0, drive}, 16'h0000);

        // R3 zero count
        acc(1'b1, 1'b0, 3'd2, 16'h0000);
        chk("R3 count out", {7'd0, sec_count}, 16'd256);
        acc(1'b0, 1'b0, 3'd2, 16'h0000);
        chk("R3 count read", last_rd, 16'h0000);

        // R11 selected command
        acc(1'b1, 1'b0, 3'd7, 16'h0020);
        chk("R11 strobe", {15'd0, cmd_stb}, 16'd1);
        chk("R11 opcode", {8'd0, cmd_opcode}, 16'h0020);
        @(negedge clk);
        chk("R11 one cycle", {15'd0, cmd_stb}, 16'd0);

        // R9 interrupt clear rules
        eng_irq();
        chk("R9 raised", {15'd0, irq}, 16'd1);
        acc(1'b0, 1'b1, 3'd6, 16'h0000);
        chk("R9 alt keeps", {15'd0, irq}, 16'd1);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R9 status clears", {15'd0, irq}, 16'd0);

        // R10 mask
        eng_irq();
        acc(1'b1, 1'b1, 3'd6, 16'h0002);
        chk("R10 masked", {15'd0, irq}, 16'd0);
        acc(1'b1, 1'b1, 3'd6, 16'h0000);
        chk("R10 unmasked", {15'd0, irq}, 16'd1);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);

        // R6 DMA acknowledge
        dmack = 1'b1;
        acc(1'b0, 1'b0, 3'd3, 16'h0000);
        chk("R6 cs0 read", last_rd, 16'hFFFF);
        acc(1'b0, 1'b1, 3'd6, 16'h0000);
        chk("R6 cs1 read", last_rd, 16'hFFFF);
        acc(1'b1, 1'b0, 3'd3, 16'h0099);
        dmack = 1'b0;
        acc(1'b0, 1'b0, 3'd3, 16'h0000);
        chk("R6 write dropped", last_rd, 16'h0021);

        // R7 busy rules, R13 engine load
        eng_load(8'hD0);
        acc(1'b1, 1'b0, 3'd3, 16'h0077);
        acc(1'b0, 1'b0, 3'd3, 16'h0000);
        chk("R7 reg read gives status", last_rd, 16'h00D0);
        acc(1'b0, 1'b0, 3'd0, 16'h0000);
        chk("R7 data read", last_rd, 16'hFFFF);
        acc(1'b1, 1'b0, 3'd7, 16'h0030);
        chk("R7 command accepted", {15'd0, cmd_stb}, 16'd1);
        eng_load(8'h51);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R13 engine status", last_rd, 16'h0051);
        acc(1'b0, 1'b0, 3'd3, 16'h0000);
        chk("R7 busy write dropped", last_rd, 16'h0021);

        // R8 DRQ rules
        acc(1'b1, 1'b0, 3'd0, 16'h4321);
        chk("R8 no drq no strobe", {15'd0, last_dwr}, 16'd0);
        eng_load(8'h58);
        acc(1'b1, 1'b0, 3'd1, 16'h0066);
        chk("R8 feature dropped", {8'd0, feature}, 16'h0012);
        acc(1'b1, 1'b0, 3'd0, 16'h1234);
        chk("R8 write strobe", {15'd0, last_dwr}, 16'd1);
        acc(1'b0, 1'b0, 3'd0, 16'h0000);
        chk("R8 data read", last_rd, 16'hBEEF);
        chk("R8 read strobe", {15'd0, last_drd}, 16'd1);
        eng_load(8'h50);

        // R4 / R5 selection, R11 diagnostic exception
        acc(1'b1, 1'b0, 3'd6, 16'h0010);
        chk("R4 drive 1", {15'd0, drive}, 16'd1);
        chk("R4 head 0", {12'd0, head}, 16'd0);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R5 other status", last_rd, 16'hFFFF);
        acc(1'b0, 1'b0, 3'd3, 16'h0000);
        chk("R5 other reg", last_rd, 16'hFFFF);
        acc(1'b1, 1'b0, 3'd7, 16'h0020);
        chk("R11 unselected no strobe", {15'd0, cmd_stb}, 16'd0);
        chk("R11 latched", {8'd0, cmd_opcode}, 16'h0020);
        acc(1'b1, 1'b0, 3'd7, 16'h0090);
        chk("R11 diag strobe", {15'd0, cmd_stb}, 16'd1);
        other_present = 1'b0;
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R5 single status", last_rd, 16'h0000);
        acc(1'b0, 1'b1, 3'd6, 16'h0000);
        chk("R5 single alt", last_rd, 16'h0000);
        acc(1'b0, 1'b0, 3'd0, 16'h0000);
        chk("R5 single data", last_rd, 16'h0000);
        acc(1'b0, 1'b0, 3'd3, 16'h0000);
        chk("R5 single reg", last_rd, 16'h0021);
        other_present = 1'b1;
        acc(1'b1, 1'b0, 3'd6, 16'h0000);

        // R12 software reset
        acc(1'b1, 1'b1, 3'd6, 16'h0004);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R12 busy", last_rd, 16'h0090);
        eng_load(8'h00);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R12 engine ignored", last_rd, 16'h0090);
        repeat (N_RST + 2) @(negedge clk);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R12 done ready", last_rd, 16'h0050);
        media_ready = 1'b0;
        acc(1'b1, 1'b1, 3'd6, 16'h0004);
        repeat (N_RST + 2) @(negedge clk);
        acc(1'b0, 1'b0, 3'd7, 16'h0000);
        chk("R12 done not ready", last_rd, 16'h0010);

        finish_run();
    end

endmodule